// File: doc/BRIEF.md
# Frequency Lock Monitor for a Multiplied Oscillator

This block decides whether a digitally controlled oscillator (DCO) runs at its target frequency. The target is a reference frequency times a factor of 1000 plus twice a 7-bit multiplier setting. The block counts DCO rising edges over every period of the chosen reference. It checks each count against the target, within a fixed tolerance, and drives a lock status output. Any change of lock caused by a measurement also raises a one-cycle change pulse.

Counting runs in the DCO clock domain. Each finished window count crosses into the monitor clock domain through a toggle request/acknowledge handshake. Inside the monitor domain the count travels as a one-cycle valid pulse. There is no back-pressure, because the evaluator takes a result in every cycle.

Two control inputs force lock low at once and without a change pulse: a strobe that marks a write to any configuration register (control, multiplier or trim), and a stop-mode request. After such a clear, the result already in flight and the next one may have been measured partly under the old conditions, so both are thrown away. Lock must then be earned again from fresh windows.

Top module: `fll_lock_monitor`

## Requirements
- R1: After reset, `lock` and `lock_chg` are 0.
- R2: The target count is 1000 + 2 × `mult`. A window count is in tolerance when it differs from the target by at most 2 counts (TOL = 2). A difference of 3 or more is out of tolerance.
- R3: While unlocked, two consecutive in-tolerance results set `lock` to 1 and raise `lock_chg` for one cycle.
- R4: While locked, a single out-of-tolerance result clears `lock` and raises `lock_chg` for one cycle.
- R5: Results that alternate between in and out of tolerance never set `lock` and produce no pulse.
- R6: A cycle with `cfg_wr` high makes `lock` 0 in the following cycle, with no `lock_chg` pulse.
- R7: While `stop_req` is high, `lock` is 0 from the following cycle onward. Results are ignored and no `lock_chg` pulse is produced.
- R8: After a clear by `cfg_wr` or `stop_req`, the next two results are discarded. Lock is set again, with a pulse, by the two in-tolerance results that follow them.
- R9: `ref_sel` = 0 measures against `irc_ref`; `ref_sel` = 1 measures against `osc_ref`.
- R10: `lock_chg` is never high for two cycles in a row. It is high only in the cycle in which `lock` takes a new value through a measurement.
- R11: The window count saturates at 4095 (2^12 − 1). A saturated count is always out of tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock; lock evaluation and outputs |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| dco_clk | input | 1 | Oscillator clock under measurement |
| irc_ref | input | 1 | Internal reference clock, sampled as data |
| osc_ref | input | 1 | Divided oscillator reference, sampled as data |
| ref_sel | input | 1 | Reference choice: 0 internal, 1 divided oscillator |
| mult | input | 7 | Multiplier setting; target = 1000 + 2·mult |
| cfg_wr | input | 1 | Configuration-write strobe; forces lock off |
| stop_req | input | 1 | Stop-mode request; holds lock off |
| lock | output | 1 | Lock status |
| lock_chg | output | 1 | One-cycle pulse when a measurement changes lock |

## Verification
The hardest behaviour to reach from the ports is the streak rule: a good window followed by a bad one must reset the count of good windows. This needs window lengths that change from one reference period to the next. The bench's reference generator reads a new period at the start of every cycle, and can alternate between a good and a bad period on every cycle. Reference edges fall on whole nanoseconds, while DCO edges fall on half nanoseconds, so every window count is exact and the tolerance edges at ±2 and ±3 can be hit precisely. A clear that lands while a result is in flight is covered by probing `lock` one window after a write, before any fresh pair of windows could exist.

// File: rtl/fll_mon_pkg.sv
`timescale 1ns/1ps
package fll_mon_pkg;

  typedef enum logic {
    LK_OFF = 1'b0,
    LK_ON  = 1'b1
  } lock_state_e;

  // Distance between two unsigned values, order independent.
  function automatic int unsigned abs_gap(input int unsigned a, input int unsigned b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/fll_dco_window.sv
`timescale 1ns/1ps
// DCO-domain window counter: counts DCO cycles between rising edges of the
// selected reference, then offers each count over a toggle handshake.
module fll_dco_window #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             dco_clk,
  input  logic             rst_n,
  input  logic             irc_ref,
  input  logic             osc_ref,
  input  logic             ref_sel,
  input  logic             ack_tgl,
  output logic             req_tgl,
  output logic [CNT_W-1:0] hold_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_N-1:0] sel_sync;
  logic [SYNC_N:0]   ref_sync;   // one extra stage for edge detection
  logic [SYNC_N-1:0] ack_sync;
  logic              ref_mux;
  logic              ref_rise;
  logic              first_done_q;
  logic              busy;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  win_cnt;
  logic              req_q;
  logic [CNT_W-1:0]  hold_q;

  // Select before synchronizing: both references are treated as data.
  assign ref_mux  = sel_sync[SYNC_N-1] ? osc_ref : irc_ref;
  assign ref_rise = ref_sync[SYNC_N-1] & ~ref_sync[SYNC_N];
  assign busy     = req_q ^ ack_sync[SYNC_N-1];
  assign win_cnt  = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge dco_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sync <= '0;
      ref_sync <= '0;
      ack_sync <= '0;
    end else begin
      sel_sync <= {sel_sync[SYNC_N-2:0], ref_sel};
      ref_sync <= {ref_sync[SYNC_N-1:0], ref_mux};
      ack_sync <= {ack_sync[SYNC_N-2:0], ack_tgl};
    end
  end

  always_ff @(posedge dco_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      first_done_q <= 1'b0;
      req_q        <= 1'b0;
      hold_q       <= '0;
    end else begin
      if (ref_rise) begin
        cnt_q        <= '0;
        first_done_q <= 1'b1;
        // The window before the first edge is partial; never offer it.
        if (first_done_q && !busy) begin
          hold_q <= win_cnt;
          req_q  <= ~req_q;
        end
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign req_tgl  = req_q;
  assign hold_cnt = hold_q;

endmodule

// File: rtl/fll_meas_rx.sv
`timescale 1ns/1ps
// Monitor-domain side of the count handshake: emits each count as a
// one-cycle valid pulse and returns the acknowledge toggle.
module fll_meas_rx #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tgl,
  input  logic [CNT_W-1:0] hold_cnt,
  output logic             ack_tgl,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_cnt
);

  logic [SYNC_N:0]  req_sync;
  logic             req_new;
  logic             ack_q;
  logic             valid_q;
  logic [CNT_W-1:0] cnt_q;

  assign req_new = req_sync[SYNC_N-1] ^ req_sync[SYNC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      ack_q    <= 1'b0;
      valid_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      req_sync <= {req_sync[SYNC_N-1:0], req_tgl};
      valid_q  <= req_new;
      if (req_new) begin
        cnt_q <= hold_cnt;                // held stable until ack returns
        ack_q <= req_sync[SYNC_N-1];
      end
    end
  end

  assign ack_tgl    = ack_q;
  assign meas_valid = valid_q;
  assign meas_cnt   = cnt_q;

  // R10: results arrive as isolated single-cycle pulses
  p_meas_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> !meas_valid);

endmodule

// File: rtl/fll_lock_eval.sv
`timescale 1ns/1ps
// Lock decision: tolerance compare, streak counting, forced clears.
module fll_lock_eval
  import fll_mon_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned MULT_W   = 7,
  parameter int unsigned BASE     = 1000,
  parameter int unsigned TOL      = 2,
  parameter int unsigned LOCK_RUN = 2,
  parameter int unsigned DISCARD  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_valid,
  input  logic [CNT_W-1:0]  meas_cnt,
  input  logic [MULT_W-1:0] mult,
  input  logic              cfg_wr,
  input  logic              stop_req,
  output logic              lock,
  output logic              lock_chg
);

  localparam int unsigned RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int unsigned SKIP_W = $clog2(DISCARD + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  lock_state_e       state_q;
  logic [RUN_W-1:0]  run_q;
  logic [SKIP_W-1:0] skip_q;
  logic              chg_q;
  logic              force_clr;
  logic              in_tol;
  int unsigned       target;

  assign force_clr = cfg_wr | stop_req;
  assign target    = BASE + 2 * int'(mult);
  assign in_tol    = (meas_cnt != CNT_MAX) &&
                     (abs_gap(int'(meas_cnt), target) <= TOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_OFF;
      run_q   <= '0;
      skip_q  <= SKIP_W'(DISCARD);
      chg_q   <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (force_clr) begin
        state_q <= LK_OFF;
        run_q   <= '0;
        skip_q  <= SKIP_W'(DISCARD);
      end else if (meas_valid) begin
        if (skip_q != '0) begin
          skip_q <= skip_q - 1'b1;
        end else if (in_tol) begin
          if (int'(run_q) < LOCK_RUN) run_q <= run_q + 1'b1;
          if (state_q == LK_OFF && int'(run_q) + 1 >= LOCK_RUN) begin
            state_q <= LK_ON;
            chg_q   <= 1'b1;
          end
        end else begin
          run_q <= '0;
          if (state_q == LK_ON) begin
            state_q <= LK_OFF;
            chg_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign lock     = (state_q == LK_ON);
  assign lock_chg = chg_q;

  // R6: a configuration write drops lock on the next cycle
  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !lock);

  // R7: stop request holds lock low
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !lock);

  // R6/R7: forced clears are silent
  p_clear_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr || stop_req) |=> !lock_chg);

  // R10: a pulse always marks a change of lock
  p_chg_marks_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_chg |-> (lock != $past(lock)));

  // R3: lock can only rise on the back of a measurement result
  p_rise_from_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(meas_valid));

endmodule

// File: rtl/fll_lock_monitor.sv
`timescale 1ns/1ps
module fll_lock_monitor #(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned MULT_W   = 7,
  parameter int unsigned BASE     = 1000,
  parameter int unsigned TOL      = 2,
  parameter int unsigned LOCK_RUN = 2,
  parameter int unsigned DISCARD  = 2,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dco_clk,
  input  logic              irc_ref,
  input  logic              osc_ref,
  input  logic              ref_sel,
  input  logic [MULT_W-1:0] mult,
  input  logic              cfg_wr,
  input  logic              stop_req,
  output logic              lock,
  output logic              lock_chg
);

  logic             req_tgl;
  logic             ack_tgl;
  logic [CNT_W-1:0] hold_cnt;
  logic             meas_valid;
  logic [CNT_W-1:0] meas_cnt;

  fll_dco_window #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_window (
    .dco_clk  (dco_clk),
    .rst_n    (rst_n),
    .irc_ref  (irc_ref),
    .osc_ref  (osc_ref),
    .ref_sel  (ref_sel),
    .ack_tgl  (ack_tgl),
    .req_tgl  (req_tgl),
    .hold_cnt (hold_cnt)
  );

  fll_meas_rx #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_tgl    (req_tgl),
    .hold_cnt   (hold_cnt),
    .ack_tgl    (ack_tgl),
    .meas_valid (meas_valid),
    .meas_cnt   (meas_cnt)
  );

  fll_lock_eval #(
    .CNT_W(CNT_W), .MULT_W(MULT_W), .BASE(BASE), .TOL(TOL),
    .LOCK_RUN(LOCK_RUN), .DISCARD(DISCARD)
  ) u_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .meas_cnt   (meas_cnt),
    .mult       (mult),
    .cfg_wr     (cfg_wr),
    .stop_req   (stop_req),
    .lock       (lock),
    .lock_chg   (lock_chg)
  );

endmodule

// File: tb/fll_lock_monitor_tb.sv
`timescale 1ns/1ps
module fll_lock_monitor_tb;

  logic       clk = 1'b0;
  logic       dco_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irc_ref = 1'b0;
  logic       osc_ref = 1'b0;
  logic       ref_sel = 1'b0;
  logic [6:0] mult = 7'd0;
  logic       cfg_wr = 1'b0;
  logic       stop_req = 1'b0;
  logic       lock;
  logic       lock_chg;

  int n_checks = 0;
  int n_fail   = 0;
  int chg_seen = 0;
  int wide_err = 0;
  logic prev_chg = 1'b0;

  int irc_per_a = 1000;
  int irc_per_b = 1000;
  bit irc_alt   = 1'b0;
  int osc_per   = 2000;

  always #2.5 clk = ~clk;
  always #0.5 dco_clk = ~dco_clk;   // rising edges at x.5 ns

  // Reference generators: period read once per cycle, edges on whole ns.
  initial begin
    bit phase = 1'b0;
    forever begin
      int p;
      p = (irc_alt && phase) ? irc_per_b : irc_per_a;
      phase = ~phase;
      irc_ref = 1'b1; #(p / 2);
      irc_ref = 1'b0; #(p - p / 2);
    end
  end

  initial begin
    forever begin
      int p;
      p = osc_per;
      osc_ref = 1'b1; #(p / 2);
      osc_ref = 1'b0; #(p - p / 2);
    end
  end

  always @(negedge clk) begin
    if (lock_chg) chg_seen++;
    if (lock_chg && prev_chg) wide_err++;
    prev_chg = lock_chg;
  end

  fll_lock_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .dco_clk(dco_clk), .irc_ref(irc_ref),
    .osc_ref(osc_ref), .ref_sel(ref_sel), .mult(mult), .cfg_wr(cfg_wr),
    .stop_req(stop_req), .lock(lock), .lock_chg(lock_chg)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input int m);
    @(negedge clk);
    mult   = 7'(m);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Vector fields: new mult (-1 = no write), period offset from target,
  // windows to run, expected lock, expected change pulses, requirement.
  localparam int NV = 9;
  localparam int VEC [NV][6] = '{
    '{  0,    0, 8, 1, 1, 3},   // R3 first lock
    '{ -1,    2, 6, 1, 0, 2},   // R2 +2 still in tolerance
    '{ -1,   -2, 6, 1, 0, 2},   // R2 -2 still in tolerance
    '{ -1,    3, 6, 0, 1, 4},   // R4 +3 drops lock
    '{ -1,   -3, 6, 0, 0, 2},   // R2 -3 stays out
    '{ -1,    0, 6, 1, 1, 3},   // R3 relock
    '{127,    0, 8, 1, 1, 8},   // R8 write then relock at top factor
    '{ 64,    1, 8, 1, 1, 8},   // R8 write then relock mid factor
    '{ -1, 4000, 3, 0, 1, 11}   // R11 saturated count
  };

  initial begin
    int cur_mult;
    int base_chg;
    int per;
    cur_mult = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(lock == 1'b0, "R1", "lock in reset", int'(lock), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(lock == 1'b0 && lock_chg == 1'b0, "R1", "outputs after reset",
          int'({lock, lock_chg}), 0);

    for (int i = 0; i < NV; i++) begin
      base_chg = chg_seen;
      if (VEC[i][0] >= 0) begin
        cur_mult = VEC[i][0];
        write_cfg(cur_mult);
      end
      per = 1000 + 2 * cur_mult + VEC[i][1];
      irc_per_a = per;
      #(VEC[i][2] * per + per);
      @(negedge clk);
      check(int'(lock) == VEC[i][3], $sformatf("R%0d", VEC[i][5]),
            $sformatf("vector %0d lock", i), int'(lock), VEC[i][3]);
      check(chg_seen - base_chg == VEC[i][4], $sformatf("R%0d", VEC[i][5]),
            $sformatf("vector %0d pulses", i), chg_seen - base_chg, VEC[i][4]);
    end

    // Directed: write while locked (R6, R8). Target is 1128 for mult 64.
    irc_per_a = 1128;
    #(9 * 1128);
    @(negedge clk);
    check(lock == 1'b1, "R3", "lock before write", int'(lock), 1);
    base_chg = chg_seen;
    write_cfg(64);
    @(negedge clk);
    check(lock == 1'b0, "R6", "lock after write", int'(lock), 0);
    check(chg_seen == base_chg, "R6", "pulses on write", chg_seen - base_chg, 0);
    #(1128);
    @(negedge clk);
    check(lock == 1'b0, "R8", "lock one window after write", int'(lock), 0);
    #(7 * 1128);
    @(negedge clk);
    check(lock == 1'b1 && chg_seen - base_chg == 1, "R8", "relock pulses",
          chg_seen - base_chg, 1);

    // Directed: stop request (R7)
    base_chg = chg_seen;
    @(negedge clk);
    stop_req = 1'b1;
    repeat (2) @(negedge clk);
    check(lock == 1'b0, "R7", "lock under stop", int'(lock), 0);
    #(6 * 1128);
    @(negedge clk);
    check(lock == 1'b0 && chg_seen == base_chg, "R7", "stop held pulses",
          chg_seen - base_chg, 0);
    stop_req = 1'b0;
    #(8 * 1128);
    @(negedge clk);
    check(lock == 1'b1 && chg_seen - base_chg == 1, "R8", "relock after stop",
          chg_seen - base_chg, 1);

    // Directed: alternating good and bad windows (R4, R5)
    base_chg = chg_seen;
    irc_per_b = 1138;
    irc_alt   = 1'b1;
    #(4 * 1138);
    @(negedge clk);
    check(lock == 1'b0 && chg_seen - base_chg == 1, "R4", "drop on bad window",
          chg_seen - base_chg, 1);
    base_chg = chg_seen;
    #(12 * 1138);
    @(negedge clk);
    check(lock == 1'b0 && chg_seen == base_chg, "R5", "alternation pulses",
          chg_seen - base_chg, 0);
    irc_alt = 1'b0;

    // Directed: reference select (R9)
    irc_per_a = 3000;
    osc_per   = 1128;
    #(4 * 3000);
    @(negedge clk);
    check(lock == 1'b0, "R9", "internal ref off target", int'(lock), 0);
    ref_sel = 1'b1;
    #(9 * 1128);
    @(negedge clk);
    check(lock == 1'b1, "R9", "locked on oscillator ref", int'(lock), 1);

    check(wide_err == 0, "R10", "pulses wider than one cycle", wide_err, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #950000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule